// File: doc/BRIEF.md
# Outbound Address Translation Table

This block widens a narrow local bus address into a full 64-bit address for an outgoing memory request. The local address is split in two: the low `WIN_W` bits form an offset that passes through untouched, and the `IDX_W` bits directly above that offset pick one of `2^IDX_W` table entries. Each entry holds a 64-bit page base. The result takes the upper part of that base above the offset window and the local offset below it. A per-request enable bypasses the table, and the local address then goes out zero-extended.

The table is loaded through a 32-bit register port. Each entry takes two word registers in a fixed layout above a base offset. The translated address leaves through a one-deep registered output stage with a valid/ready handshake. The burst length and a request tag travel alongside the address. Two flags tell the downstream packet builder whether the address fits a 32-bit or needs a 64-bit format. Keeping a burst inside one page is the requester's job: the block does not check that rule and does not report a breach.

The output stage is a two-state machine. `OAT_EMPTY` holds nothing. `OAT_FULL` holds one result. The transitions are FILL (EMPTY to FULL on accept), REFILL (FULL to FULL when the result leaves and a new one is accepted in the same cycle), DRAIN (FULL to EMPTY when the result leaves and nothing new arrives) and STALL (FULL to FULL while the consumer holds ready low). EMPTY stays in EMPTY while no request arrives.

Top module: `outb_xlat_top`

## Requirements
- R1: After reset every table word reads zero, `out_valid` is 0 and `req_ready` is 1.
- R2: A register write with a byte address `CFG_BASE + 8*i` (bits [1:0] = 00) sets the low word of entry i. The address `CFG_BASE + 8*i + 4` sets the high word. Only that 32-bit half changes. Asserting `cfg_rd_en` gives `cfg_rvalid` one cycle later, with `cfg_rdata` holding the stored word.
- R3: A register access below `CFG_BASE`, at or above `CFG_BASE + 8*2^IDX_W`, or with address bits [1:0] not 00 changes no entry and reads back zero.
- R4: With `xlat_en` = 1, `out_addr` = {entry[63:WIN_W], req_addr[WIN_W-1:0]}, where the entry index is req_addr[WIN_W+IDX_W-1:WIN_W]. Entry bits below WIN_W have no effect.
- R5: With WIN_W = 16 and IDX_W = 4, entry 3 holding low word 0x56780000 and high word 0x00012340, the local address 0x39AB0 gives 0x0001234056789AB0.
- R6: With `xlat_en` = 0, `out_addr` is `req_addr` zero-extended to 64 bits.
- R7: `out_addr32` is 1 exactly when `out_addr[63:32]` is zero. `out_addr64` is its complement.
- R8: A request is taken when `req_valid` and `req_ready` are both 1. Its result shows `out_valid` = 1 on the next cycle, with `out_burst` and `out_tag` equal to the request's burst and tag.
- R9: While `out_valid` = 1 and `out_ready` = 0, `req_ready` is 0 and every output field stays unchanged.
- R10: A table write in the same cycle as a lookup of the same entry gives the lookup the old value. Lookups from the next cycle on see the new value.
- R11: A request whose burst runs past the end of its page is translated like any other, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | 1 = use the table, 0 = pass the address through |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | LOCAL_AW | Local address |
| req_burst | input | BURST_W | Burst length carried along |
| req_tag | input | TAG_W | Tag carried along |
| out_valid | output | 1 | Translated result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Translated address |
| out_addr32 | output | 1 | Address fits the 32-bit format |
| out_addr64 | output | 1 | Address needs the 64-bit format |
| out_burst | output | BURST_W | Burst length of the result |
| out_tag | output | TAG_W | Tag of the result |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |

## Verification
The bench loads every entry with distinct words whose low bits are non-zero. A design that forgot to mask them would corrupt the offset field. It then sweeps each entry at the bottom, top and middle of its window, so an index taken one bit too low or too high lands on the wrong entry. Entries with a zero high word check the 32-bit flag, where an inverted or stale flag would pick the wrong format. Separate cases cover a write racing a lookup of the same entry, which would leak the new value early if the write bypassed into the read. A stalled output is overwritten while the stall lasts in a broken design. Half-word writes would clobber the other word if the decode were loose. Out-of-range and misaligned register addresses would alias onto real entries. A burst overrunning its page would be altered or dropped if the block wrongly checked it.

// File: rtl/oat_pkg.sv
package oat_pkg;

    localparam int OUT_AW = 64;
    localparam int CFG_DW = 32;

    // Output holding stage occupancy
    typedef enum logic {
        OAT_EMPTY = 1'b0,
        OAT_FULL  = 1'b1
    } oat_state_e;

    // Result of one translation before it is registered
    typedef struct packed {
        logic [OUT_AW-1:0] addr;
        logic              is32;
    } oat_xlat_t;

endpackage

// File: rtl/oat_cfg_decode.sv
module oat_cfg_decode #(
    parameter int                CFG_AW   = 14,
    parameter int                IDX_W    = 4,
    parameter logic [CFG_AW-1:0] CFG_BASE = 14'h3000
) (
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic                    cfg_wr_en,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic                    half_hi,
    output logic [(1<<IDX_W)-1:0]   wr_lo,
    output logic [(1<<IDX_W)-1:0]   wr_hi
);
    localparam int              DEPTH = 1 << IDX_W;
    localparam logic [CFG_AW:0] SPAN  = (CFG_AW+1)'(DEPTH * 8);

    logic [CFG_AW-1:0] offset;

    always_comb begin
        offset  = cfg_addr - CFG_BASE;
        hit     = (cfg_addr >= CFG_BASE) &&
                  ({1'b0, offset} < SPAN) &&
                  (offset[1:0] == 2'b00);
        idx     = offset[IDX_W+2:3];
        half_hi = offset[2];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_strobe
        always_comb begin
            wr_lo[g] = cfg_wr_en && hit && !half_hi && (idx == IDX_W'(g));
            wr_hi[g] = cfg_wr_en && hit &&  half_hi && (idx == IDX_W'(g));
        end
    end

endmodule

// File: rtl/oat_entry_table.sv
module oat_entry_table #(
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<IDX_W)-1:0] wr_lo,
    input  logic [(1<<IDX_W)-1:0] wr_hi,
    input  logic [31:0]           wdata,
    input  logic [IDX_W-1:0]      look_idx,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [63:0]           look_entry,
    output logic [63:0]           rd_entry
);
    localparam int DEPTH = 1 << IDX_W;

    logic [63:0] ent_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [31:0] lo_r;
        logic [31:0] hi_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_r <= '0;
                hi_r <= '0;
            end else begin
                if (wr_lo[g]) lo_r <= wdata;
                if (wr_hi[g]) hi_r <= wdata;
            end
        end

        assign ent_w[g] = {hi_r, lo_r};
    end

    // Reads see register contents, so a same-edge write is not visible yet
    assign look_entry = ent_w[look_idx];
    assign rd_entry   = ent_w[rd_idx];

endmodule

// File: rtl/oat_addr_compose.sv
module oat_addr_compose
    import oat_pkg::*;
#(
    parameter int LOCAL_AW = 20,
    parameter int WIN_W    = 16
) (
    input  logic                xlat_en,
    input  logic [LOCAL_AW-1:0] local_addr,
    input  logic [OUT_AW-1:0]   entry,
    output oat_xlat_t           res
);
    localparam logic [OUT_AW-1:0] LO_MASK = (64'd1 << WIN_W) - 64'd1;

    logic [OUT_AW-1:0] local_ext;
    logic [OUT_AW-1:0] mapped;

    always_comb begin
        local_ext = OUT_AW'(local_addr);
        mapped    = (entry & ~LO_MASK) | (local_ext & LO_MASK);
        res.addr  = xlat_en ? mapped : local_ext;
        res.is32  = (res.addr[OUT_AW-1:32] == '0);
    end

endmodule

// File: rtl/oat_out_stage.sv
module oat_out_stage
    import oat_pkg::*;
#(
    parameter int BURST_W = 8,
    parameter int TAG_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  oat_xlat_t          in_res,
    input  logic [BURST_W-1:0] in_burst,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_AW-1:0]  out_addr,
    output logic               out_addr32,
    output logic               out_addr64,
    output logic [BURST_W-1:0] out_burst,
    output logic [TAG_W-1:0]   out_tag
);
    oat_state_e state_q, state_d;
    logic       load;

    assign in_ready = (state_q == OAT_EMPTY) || out_ready;
    assign load     = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OAT_EMPTY: if (load) state_d = OAT_FULL;              // FILL
            OAT_FULL: begin
                if (out_ready && !in_valid) state_d = OAT_EMPTY;  // DRAIN
                else                        state_d = OAT_FULL;   // REFILL / STALL
            end
            default: state_d = OAT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OAT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_addr32 <= 1'b1;
            out_burst  <= '0;
            out_tag    <= '0;
        end else if (load) begin
            out_addr   <= in_res.addr;
            out_addr32 <= in_res.is32;
            out_burst  <= in_burst;
            out_tag    <= in_tag;
        end
    end

    assign out_valid  = (state_q == OAT_FULL);
    assign out_addr64 = !out_addr32;

endmodule

// File: rtl/outb_xlat_top.sv
module outb_xlat_top
    import oat_pkg::*;
#(
    parameter int                LOCAL_AW = 20,
    parameter int                WIN_W    = 16,
    parameter int                IDX_W    = 4,
    parameter int                BURST_W  = 8,
    parameter int                TAG_W    = 6,
    parameter int                CFG_AW   = 14,
    parameter logic [CFG_AW-1:0] CFG_BASE = 14'h3000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xlat_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LOCAL_AW-1:0] req_addr,
    input  logic [BURST_W-1:0]  req_burst,
    input  logic [TAG_W-1:0]    req_tag,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [63:0]         out_addr,
    output logic                out_addr32,
    output logic                out_addr64,
    output logic [BURST_W-1:0]  out_burst,
    output logic [TAG_W-1:0]    out_tag,
    input  logic                cfg_wr_en,
    input  logic                cfg_rd_en,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic                cfg_rvalid,
    output logic [31:0]         cfg_rdata
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int IDX_LO = WIN_W;
    localparam int IDX_HI = WIN_W + IDX_W - 1;

    logic                 dec_hit;
    logic [IDX_W-1:0]     dec_idx;
    logic                 dec_half_hi;
    logic [DEPTH-1:0]     wr_lo;
    logic [DEPTH-1:0]     wr_hi;
    logic [OUT_AW-1:0]    look_entry;
    logic [OUT_AW-1:0]    rd_entry;
    oat_xlat_t            xres;

    oat_cfg_decode #(
        .CFG_AW  (CFG_AW),
        .IDX_W   (IDX_W),
        .CFG_BASE(CFG_BASE)
    ) dec_i (
        .cfg_addr (cfg_addr),
        .cfg_wr_en(cfg_wr_en),
        .hit      (dec_hit),
        .idx      (dec_idx),
        .half_hi  (dec_half_hi),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    oat_entry_table #(
        .IDX_W(IDX_W)
    ) tbl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (cfg_wdata),
        .look_idx  (req_addr[IDX_HI:IDX_LO]),
        .rd_idx    (dec_idx),
        .look_entry(look_entry),
        .rd_entry  (rd_entry)
    );

    oat_addr_compose #(
        .LOCAL_AW(LOCAL_AW),
        .WIN_W   (WIN_W)
    ) cmp_i (
        .xlat_en   (xlat_en),
        .local_addr(req_addr),
        .entry     (look_entry),
        .res       (xres)
    );

    oat_out_stage #(
        .BURST_W(BURST_W),
        .TAG_W  (TAG_W)
    ) ostg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_res    (xres),
        .in_burst  (req_burst),
        .in_tag    (req_tag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_addr32(out_addr32),
        .out_addr64(out_addr64),
        .out_burst (out_burst),
        .out_tag   (out_tag)
    );

    // Register read-back, one cycle after the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd_en;
            if (cfg_rd_en) begin
                if (!dec_hit)         cfg_rdata <= '0;
                else if (dec_half_hi) cfg_rdata <= rd_entry[63:32];
                else                  cfg_rdata <= rd_entry[31:0];
            end
        end
    end

endmodule

// File: rtl/oat_checker.sv
module oat_checker #(
    parameter int LOCAL_AW = 20,
    parameter int WIN_W    = 16,
    parameter int BURST_W  = 8,
    parameter int TAG_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                xlat_en,
    input logic                req_valid,
    input logic                req_ready,
    input logic [LOCAL_AW-1:0] req_addr,
    input logic [BURST_W-1:0]  req_burst,
    input logic [TAG_W-1:0]    req_tag,
    input logic                out_valid,
    input logic                out_ready,
    input logic [63:0]         out_addr,
    input logic                out_addr32,
    input logic                out_addr64,
    input logic [BURST_W-1:0]  out_burst,
    input logic [TAG_W-1:0]    out_tag,
    input logic                cfg_rd_en,
    input logic                cfg_rvalid
);
    AST_FMT_MATCHES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr32 == (out_addr[63:32] == 32'd0))); // R7
    AST_FMT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr32 != out_addr64)); // R7
    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid); // R8
    AST_SIDEBAND_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_tag == $past(req_tag) && out_burst == $past(req_burst))); // R8
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_addr[WIN_W-1:0] == $past(req_addr[WIN_W-1:0]))); // R4
    AST_BYPASS_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=> (out_addr == 64'($past(req_addr)))); // R6
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !req_ready); // R9
    AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_tag) && $stable(out_burst))); // R9
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rvalid); // R2
endmodule

bind outb_xlat_top oat_checker #(
    .LOCAL_AW(LOCAL_AW),
    .WIN_W   (WIN_W),
    .BURST_W (BURST_W),
    .TAG_W   (TAG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_burst (req_burst),
    .req_tag   (req_tag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_addr32(out_addr32),
    .out_addr64(out_addr64),
    .out_burst (out_burst),
    .out_tag   (out_tag),
    .cfg_rd_en (cfg_rd_en),
    .cfg_rvalid(cfg_rvalid)
);

// File: tb/outb_xlat_top_tb_top.sv
`timescale 1ns/1ps
module outb_xlat_top_tb_top;
    localparam int LAW = 20;
    localparam int W   = 16;
    localparam int T   = 4;
    localparam int N   = 1 << T;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_burst = '0;
    logic [5:0]  req_tag = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_addr;
    logic        out_addr32, out_addr64;
    logic [7:0]  out_burst;
    logic [5:0]  out_tag;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];

    always #2.5 clk = ~clk;

    outb_xlat_top dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_burst(req_burst), .req_tag(req_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_addr32(out_addr32), .out_addr64(out_addr64),
        .out_burst(out_burst), .out_tag(out_tag),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic en, input logic [19:0] a);
        logic [63:0] ent;
        logic [63:0] msk;
        if (!en) return 64'(a);
        ent = {m_hi[a[W+T-1:W]], m_lo[a[W+T-1:W]]};
        msk = (64'd1 << W) - 64'd1;
        return (ent & ~msk) | (64'(a) & msk);
    endfunction

    task automatic cfg_wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_rd_chk(input string req, input logic [13:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        chk({req, " rvalid"}, 64'(cfg_rvalid), 64'd1);
        chk(req, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic xlat_chk(input string req, input logic en, input logic [19:0] a,
                            input logic [7:0] b, input logic [5:0] t);
        logic [63:0] e;
        e = model(en, a);
        @(negedge clk);
        xlat_en = en; req_valid = 1'b1; req_addr = a; req_burst = b; req_tag = t;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk(req, out_addr, e);
        chk({req, " R7 fmt"}, {62'd0, out_addr32, out_addr64},
            (e[63:32] == 32'd0) ? 64'd2 : 64'd1);
        chk({req, " R8 side"}, {50'd0, out_burst, out_tag}, {50'd0, b, t});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        cfg_rd_chk("R1 entry0 lo", 14'h3000, 32'd0);
        cfg_rd_chk("R1 entry15 hi", 14'h307C, 32'd0);
        xlat_chk("R1 zero table", 1'b1, 20'hA1234, 8'd1, 6'd1);

        // R2: fill table, low bits set in every low word
        for (int i = 0; i < N; i++) begin
            m_lo[i] = 32'hA5C3_0000 ^ (i * 32'h0111_1111) ^ 32'h0000_FFFF;
            m_hi[i] = (i % 4 == 0) ? 32'd0 : i * 32'h1357_9BDF;
            cfg_wr(14'(32'h3000 + 8 * i), m_lo[i]);
            cfg_wr(14'(32'h3004 + 8 * i), m_hi[i]);
        end
        for (int i = 0; i < N; i++) begin
            cfg_rd_chk("R2 readback lo", 14'(32'h3000 + 8 * i), m_lo[i]);
            cfg_rd_chk("R2 readback hi", 14'(32'h3004 + 8 * i), m_hi[i]);
        end
        // R2: half write leaves the other half
        m_lo[5] = 32'h0BAD_F00D;
        cfg_wr(14'h3028, m_lo[5]);
        cfg_rd_chk("R2 other half kept", 14'h302C, m_hi[5]);
        cfg_rd_chk("R2 half updated", 14'h3028, m_lo[5]);

        // R3: out-of-range and misaligned accesses
        cfg_wr(14'h3080, 32'hDEAD_BEEF);
        cfg_wr(14'h2FFC, 32'hDEAD_BEEF);
        cfg_wr(14'h3002, 32'hDEAD_BEEF);
        cfg_rd_chk("R3 above range reads 0", 14'h3080, 32'd0);
        cfg_rd_chk("R3 below range reads 0", 14'h2FFC, 32'd0);
        cfg_rd_chk("R3 misaligned reads 0", 14'h3006, 32'd0);
        cfg_rd_chk("R3 entry0 lo untouched", 14'h3000, m_lo[0]);
        cfg_rd_chk("R3 entry15 hi untouched", 14'h307C, m_hi[15]);

        // R4 / R7 / R8: sweep every entry over its window
        for (int i = 0; i < N; i++) begin
            xlat_chk("R4 win bottom", 1'b1, {4'(i), 16'h0000}, 8'(i), 6'(i));
            xlat_chk("R4 win top", 1'b1, {4'(i), 16'hFFFF}, 8'(i + 1), 6'(i + 2));
            xlat_chk("R4 win mid", 1'b1, {4'(i), 16'h9AB0}, 8'(3), 6'(i + 3));
            xlat_chk("R4 win pattern", 1'b1, {4'(i), 16'(i * 16'h1111)}, 8'd7, 6'(i));
        end

        // R6: bypass sweep
        for (int i = 0; i < N; i++)
            xlat_chk("R6 bypass", 1'b0, {4'(i), 16'(16'h5A5A ^ (i * 16'h0F0F))}, 8'd2, 6'(i));

        // R5: worked example
        m_lo[3] = 32'h5678_0000; m_hi[3] = 32'h0001_2340;
        cfg_wr(14'h3018, m_lo[3]);
        cfg_wr(14'h301C, m_hi[3]);
        xlat_chk("R5 example", 1'b1, 20'h39AB0, 8'd4, 6'd33);
        chk("R5 exact", out_addr, 64'h0001_2340_5678_9AB0);

        // R11: burst running past page end
        xlat_chk("R11 crossing burst", 1'b1, {4'd9, 16'hFFF0}, 8'd200, 6'd9);

        // R10: write and lookup of entry 7 in the same cycle
        begin
            logic [63:0] old_e;
            old_e = model(1'b1, {4'd7, 16'h1234});
            @(negedge clk);
            cfg_wr_en = 1'b1; cfg_addr = 14'h303C; cfg_wdata = 32'hCAFE_0001;
            xlat_en = 1'b1; req_valid = 1'b1; req_addr = {4'd7, 16'h1234};
            req_burst = 8'd1; req_tag = 6'd7;
            @(negedge clk);
            cfg_wr_en = 1'b0; req_valid = 1'b0;
            chk("R10 old value on race", out_addr, old_e);
            m_hi[7] = 32'hCAFE_0001;
            xlat_chk("R10 new value after", 1'b1, {4'd7, 16'h1234}, 8'd1, 6'd8);
        end

        // R9: stall holds the result and blocks input
        begin
            logic [63:0] e1, e2;
            e1 = model(1'b1, {4'd2, 16'h0102});
            e2 = model(1'b1, {4'd6, 16'h0304});
            @(negedge clk);
            out_ready = 1'b0; xlat_en = 1'b1;
            req_valid = 1'b1; req_addr = {4'd2, 16'h0102}; req_tag = 6'd21; req_burst = 8'd5;
            @(negedge clk);
            req_addr = {4'd6, 16'h0304}; req_tag = 6'd22; req_burst = 8'd6;
            chk("R9 ready low in stall", 64'(req_ready), 64'd0);
            repeat (3) @(negedge clk);
            chk("R9 addr held", out_addr, e1);
            chk("R9 tag held", 64'(out_tag), 64'd21);
            chk("R9 valid held", 64'(out_valid), 64'd1);
            out_ready = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R9 next after release", out_addr, e2);
            chk("R9 next tag", 64'(out_tag), 64'd22);
            @(negedge clk);
            chk("R8 drained", 64'(out_valid), 64'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule